// File: doc/BRIEF.md
# Dual-Protocol Multiplexed Bus Slave

This block is the host-facing front end of a small register device. It sits on a byte-wide bus where address and data share the same eight lines. A static mode pin picks one of two strobe conventions. In the first, a data strobe marks the active window and a direction line tells read from write. In the second, one active-low line enables read output and another active-low line enables writes. The block oversamples every bus line with its system clock. It takes the address from the shared lines when the address strobe falls. It qualifies each access with chip select and with an inhibit input that stands for a supply fault. It then issues single-cycle strobes toward a 128-location map.

Locations 0x00 to 0x0D go to a control register port and 0x0E to 0x7F go to a general-purpose RAM port. The block also enforces write protection. Two control locations cannot be written, and one location has a protected top bit. A latched address serves exactly one data phase. The next rising address strobe invalidates it, and so does the end of any data phase, even one without chip select. This means every access needs a fresh address strobe.

Top module: `dual_strobe_slave`

## Requirements
- R1: The falling edge of `as_i` captures `ad_i[6:0]` as the access address, shown on `acc_addr`. Bit 7 of the address byte is not used.
- R2: A rising edge of `as_i` invalidates the latched address. A data phase that follows while `as_i` is still high produces no write strobe, no read strobe and no bus drive.
- R3: With `bus_moto`=1, a falling edge of `ds_i` while `rw_i` is low and the cycle is qualified gives exactly one single-cycle write strobe. `wr_data` then holds the bus byte that was present before that edge.
- R4: With `bus_moto`=0, a rising edge of `rw_i` on a qualified cycle gives exactly one single-cycle write strobe. `wr_data` then holds the bus byte that was present before that edge.
- R5: With `bus_moto`=1, `ad_oe` is high and `ad_o` carries the read data while `ds_i` and `rw_i` are both high on a qualified cycle. `ad_oe` returns low after `ds_i` falls.
- R6: With `bus_moto`=0, `ad_oe` is high while `ds_i` is low and `rw_i` is high on a qualified cycle. `ad_oe` returns low after `ds_i` rises.
- R7: A data phase with `cs_n_i` high performs no access and uses up the latched address. A later selected data phase without a new address strobe performs no access.
- R8: Writes to 0x0C and 0x0D are dropped, so no strobe is issued. A write to 0x0A gives `wr_mask`=0x7F, and every other register write gives 0xFF.
- R9: Addresses 0x00–0x0D use `reg_wr`, `reg_rd` and `reg_rdata`. Addresses 0x0E–0x7F use `ram_wr`, `ram_rd` and `ram_rdata`. Each read window gives one single-cycle read strobe on the selected port, and the two ports are never strobed together.
- R10: While `pf_inhibit` is high, no write strobe, no read strobe and no bus drive occur.
- R11: During and right after reset, `ad_oe`, `reg_wr`, `ram_wr`, `reg_rd` and `ram_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_moto | input | 1 | Protocol select: 1 = data strobe plus direction line, 0 = separate read and write enables |
| as_i | input | 1 | Address strobe, active high pulse |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| rw_i | input | 1 | Direction, high = read (mode 1), or active-low write enable (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| pf_inhibit | input | 1 | Supply-fault access inhibit, active high |
| ad_i | input | 8 | Shared address/data lines, input side |
| ad_o | output | 8 | Read data toward the shared lines |
| ad_oe | output | 1 | Output enable for `ad_o` |
| acc_addr | output | 7 | Latched access address |
| wr_data | output | 8 | Write byte, valid with a write strobe |
| wr_mask | output | 8 | Writable bits of `wr_data` |
| reg_wr | output | 1 | Control register write strobe |
| reg_rd | output | 1 | Control register read strobe |
| reg_rdata | input | 8 | Control register read data for `acc_addr` |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data for `acc_addr` |

## Verification
Every bus line passes through two synchronizer flops and one edge-detect register before the output register. A strobe or `ad_oe` change therefore shows up on the third clock edge after the input moves. The bench holds each bus phase for six clocks and samples at falling clock edges at the end of a phase, so each result is read after it has settled. Write and read strobes are counted on every rising edge, and the address, data and mask are captured there. The checks compare the count added by each bus cycle against 0 or 1. This catches both a missing pulse and a duplicate one. All 128 addresses are swept in both protocols.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic {PROTO_ENABLES = 1'b0, PROTO_STROBE = 1'b1} proto_e;
endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int             W      = 8,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dsb_addr_latch.sv
module dsb_addr_latch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_fall,
  input  logic              as_rise,
  input  logic              cyc_end,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_v
);
  logic [ADDR_W-1:0] addr_d;
  logic              v_d;

  always_comb begin
    addr_d = addr_q;
    v_d    = addr_v;
    if (as_fall) begin
      addr_d = addr_in;
      v_d    = 1'b1;
    end else if (as_rise || cyc_end) begin
      v_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      addr_v <= 1'b0;
    end else begin
      addr_q <= addr_d;
      addr_v <= v_d;
    end
  end
endmodule

// File: rtl/dsb_strobe_decode.sv
module dsb_strobe_decode
  import dsb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              moto,
  input  logic              as_s,
  input  logic              ds_s,
  input  logic              rw_s,
  input  logic              cs_n_s,
  input  logic              inh_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic              addr_v,
  output logic              as_fall,
  output logic              as_rise,
  output logic              cyc_end,
  output logic              wr_fire,
  output logic [DATA_W-1:0] wr_word,
  output logic              rd_win
);
  logic              p_as, p_ds, p_rw, p_cs_n;
  logic [DATA_W-1:0] p_ad;
  logic              ds_fall, ds_rise, rw_rise, qual_prev, qual_now;
  proto_e            proto;

  always_comb begin
    proto     = proto_e'(moto);
    as_fall   = p_as & ~as_s;
    as_rise   = ~p_as & as_s;
    ds_fall   = p_ds & ~ds_s;
    ds_rise   = ~p_ds & ds_s;
    rw_rise   = ~p_rw & rw_s;
    qual_prev = addr_v & ~p_cs_n & ~inh_s;
    qual_now  = addr_v & ~cs_n_s & ~inh_s;
    wr_word   = p_ad;
    if (proto == PROTO_STROBE) begin
      cyc_end = ds_fall;
      wr_fire = ds_fall & ~p_rw & qual_prev;
      rd_win  = qual_now & rw_s & ds_s;
    end else begin
      cyc_end = ds_rise | rw_rise;
      wr_fire = rw_rise & qual_prev;
      rd_win  = qual_now & rw_s & ~ds_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_as   <= 1'b0;
      p_ds   <= 1'b0;
      p_rw   <= 1'b1;
      p_cs_n <= 1'b1;
      p_ad   <= '0;
    end else begin
      p_as   <= as_s;
      p_ds   <= ds_s;
      p_rw   <= rw_s;
      p_cs_n <= cs_n_s;
      p_ad   <= ad_s;
    end
  end
endmodule

// File: rtl/dsb_map.sv
module dsb_map #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int REG_COUNT  = 14,
  parameter int RO_FIRST   = 12,
  parameter int RO_LAST    = 13,
  parameter int PART_REG   = 10,
  parameter int PART_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_win,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              reg_wr,
  output logic              ram_wr,
  output logic              reg_rd,
  output logic              ram_rd,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe
);
  localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] RO_LO   = ADDR_W'(RO_FIRST);
  localparam logic [ADDR_W-1:0] RO_HI   = ADDR_W'(RO_LAST);
  localparam logic [ADDR_W-1:0] PART_A  = ADDR_W'(PART_REG);

  logic              is_reg, is_ro, is_part, rd_open;
  logic              reg_wr_d, ram_wr_d, reg_rd_d, ram_rd_d;
  logic [DATA_W-1:0] mask_d, rdata_d;

  assign is_reg  = addr < REG_END;
  assign is_ro   = (addr >= RO_LO) && (addr <= RO_HI);
  assign is_part = addr == PART_A;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b == PART_BIT) begin : g_prot
      assign mask_d[b] = ~is_part;
    end else begin : g_open
      assign mask_d[b] = 1'b1;
    end
  end

  always_comb begin
    rd_open  = rd_win & ~ad_oe;
    reg_wr_d = wr_fire & is_reg & ~is_ro;
    ram_wr_d = wr_fire & ~is_reg;
    reg_rd_d = rd_open & is_reg;
    ram_rd_d = rd_open & ~is_reg;
    rdata_d  = is_reg ? reg_rdata : ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr  <= 1'b0;
      ram_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      ram_rd  <= 1'b0;
      ad_oe   <= 1'b0;
      ad_o    <= '0;
      wr_data <= '0;
      wr_mask <= '0;
    end else begin
      reg_wr <= reg_wr_d;
      ram_wr <= ram_wr_d;
      reg_rd <= reg_rd_d;
      ram_rd <= ram_rd_d;
      ad_oe  <= rd_win;
      if (rd_win) ad_o <= rdata_d;
      if (wr_fire) begin
        wr_data <= wr_word;
        wr_mask <= mask_d;
      end
    end
  end
endmodule

// File: rtl/dual_strobe_slave.sv
module dual_strobe_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REG_COUNT   = 14,
  parameter int RO_FIRST    = 12,
  parameter int RO_LAST     = 13,
  parameter int PART_REG    = 10,
  parameter int PART_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_moto,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              cs_n_i,
  input  logic              pf_inhibit,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_mask,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              ram_wr,
  output logic              ram_rd,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int           SW      = DATA_W + 6;
  localparam logic [SW-1:0] SYNC_RST = SW'(7) << DATA_W;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [SW-1:0]     raw_bus, s_bus;
  logic              s_moto, s_as, s_ds, s_rw, s_cs_n, s_inh;
  logic [DATA_W-1:0] s_ad;
  logic              as_fall, as_rise, cyc_end, wr_fire, rd_win, addr_v;
  logic [DATA_W-1:0] wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign raw_bus = {bus_moto, as_i, ds_i, rw_i, cs_n_i, pf_inhibit, ad_i};

  dsb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw_bus), .q(s_bus)
  );

  assign {s_moto, s_as, s_ds, s_rw, s_cs_n, s_inh, s_ad} = s_bus;

  dsb_strobe_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .moto(s_moto), .as_s(s_as), .ds_s(s_ds),
    .rw_s(s_rw), .cs_n_s(s_cs_n), .inh_s(s_inh), .ad_s(s_ad), .addr_v(addr_v),
    .as_fall(as_fall), .as_rise(as_rise), .cyc_end(cyc_end),
    .wr_fire(wr_fire), .wr_word(wr_word), .rd_win(rd_win)
  );

  dsb_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .as_fall(as_fall), .as_rise(as_rise),
    .cyc_end(cyc_end), .addr_in(s_ad[ADDR_W-1:0]), .addr_q(acc_addr),
    .addr_v(addr_v)
  );

  dsb_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
    .RO_FIRST(RO_FIRST), .RO_LAST(RO_LAST), .PART_REG(PART_REG),
    .PART_BIT(PART_BIT)
  ) u_map (
    .clk(clk), .rst_n(rst_int_n), .addr(acc_addr), .wr_fire(wr_fire),
    .wr_word(wr_word), .rd_win(rd_win), .reg_rdata(reg_rdata),
    .ram_rdata(ram_rdata), .reg_wr(reg_wr), .ram_wr(ram_wr),
    .reg_rd(reg_rd), .ram_rd(ram_rd), .wr_data(wr_data),
    .wr_mask(wr_mask), .ad_o(ad_o), .ad_oe(ad_oe)
  );
endmodule

// File: rtl/dual_strobe_slave_chk.sv
module dual_strobe_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pf_inhibit,
  input logic       reg_wr,
  input logic       ram_wr,
  input logic       reg_rd,
  input logic       ram_rd,
  input logic       ad_oe,
  input logic [6:0] acc_addr
);
  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((reg_wr || reg_rd) && (ram_wr || ram_rd)));

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || ram_wr) |=> !(reg_wr || ram_wr));

  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || ram_rd) |=> !(reg_rd || ram_rd));

  // R8
  ro_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (acc_addr < 7'd12));

  // R9
  ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr || ram_rd) |-> (acc_addr >= 7'd14));

  // R10
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_inhibit && $past(pf_inhibit) && $past(pf_inhibit, 2) && $past(pf_inhibit, 3))
      |-> !(reg_wr || ram_wr || reg_rd || ram_rd || ad_oe));
endmodule

bind dual_strobe_slave dual_strobe_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pf_inhibit(pf_inhibit), .reg_wr(reg_wr),
  .ram_wr(ram_wr), .reg_rd(reg_rd), .ram_rd(ram_rd), .ad_oe(ad_oe),
  .acc_addr(acc_addr)
);

// File: tb/dual_strobe_slave_tb.sv
`timescale 1ns/1ps
module dual_strobe_slave_tb;
  localparam int PH = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_moto, as_i, ds_i, rw_i, cs_n_i, pf_inhibit;
  logic [7:0] ad_i, ad_o, wr_data, wr_mask, reg_rdata, ram_rdata;
  logic       ad_oe, reg_wr, reg_rd, ram_wr, ram_rd;
  logic [6:0] acc_addr;

  int checks = 0, errors = 0;
  int n_reg_wr = 0, n_ram_wr = 0, n_reg_rd = 0, n_ram_rd = 0;
  logic [6:0] cap_addr;
  logic [7:0] cap_data, cap_mask;
  bit done = 0;

  always #4 clk = ~clk;

  assign reg_rdata = {1'b1, acc_addr} ^ 8'h3C;
  assign ram_rdata = {1'b0, acc_addr} ^ 8'hC3;

  dual_strobe_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_moto(bus_moto), .as_i(as_i), .ds_i(ds_i),
    .rw_i(rw_i), .cs_n_i(cs_n_i), .pf_inhibit(pf_inhibit), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe(ad_oe), .acc_addr(acc_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin n_reg_wr++; cap_addr = acc_addr; cap_data = wr_data; cap_mask = wr_mask; end
    if (ram_wr) begin n_ram_wr++; cap_addr = acc_addr; cap_data = wr_data; cap_mask = wr_mask; end
    if (reg_rd) n_reg_rd++;
    if (ram_rd) n_ram_rd++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] wdat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [7:0] rdat(input int a);
    return (a < 14) ? ({1'b1, 7'(a)} ^ 8'h3C) : ({1'b0, 7'(a)} ^ 8'hC3);
  endfunction

  task automatic idle();
    as_i = 1'b0; cs_n_i = 1'b1; rw_i = 1'b1;
    ds_i = bus_moto ? 1'b0 : 1'b1;
    waitc(PH);
  endtask

  task automatic addr_phase(input int a);
    ad_i = 8'(a) | 8'h80;
    as_i = 1'b1; waitc(PH);
    as_i = 1'b0; waitc(PH);
  endtask

  task automatic data_write(input logic [7:0] d, input bit sel);
    cs_n_i = ~sel; ad_i = d;
    if (bus_moto) begin
      rw_i = 1'b0; waitc(PH);
      ds_i = 1'b1; waitc(PH);
      ds_i = 1'b0; waitc(PH);
      rw_i = 1'b1;
    end else begin
      rw_i = 1'b0; waitc(PH);
      rw_i = 1'b1; waitc(PH);
    end
    cs_n_i = 1'b1; waitc(PH);
  endtask

  task automatic data_read(input bit sel, output logic oe_mid, output logic [7:0] d_mid,
                           output logic oe_end);
    cs_n_i = ~sel; rw_i = 1'b1; ad_i = 8'h00;
    ds_i = bus_moto ? 1'b1 : 1'b0; waitc(PH);
    oe_mid = ad_oe; d_mid = ad_o;
    ds_i = bus_moto ? 1'b0 : 1'b1; waitc(PH);
    oe_end = ad_oe;
    cs_n_i = 1'b1; waitc(PH);
  endtask

  task automatic sweep(input bit moto);
    string tw, tr;
    bus_moto = moto; idle(); waitc(PH);
    tw = moto ? "R3" : "R4";
    tr = moto ? "R5" : "R6";
    for (int a = 0; a < 128; a++) begin
      int r0 = n_reg_wr, m0 = n_ram_wr, rr0 = n_reg_rd, mr0 = n_ram_rd;
      bit exp_reg = (a < 12);
      bit exp_ram = (a >= 14);
      logic om, oe;
      logic [7:0] dm;
      addr_phase(a);
      data_write(wdat(a), 1'b1);
      check(n_reg_wr - r0 == int'(exp_reg), {tw, "/R8 reg write count"}, n_reg_wr - r0, int'(exp_reg));
      check(n_ram_wr - m0 == int'(exp_ram), {tw, "/R9 ram write count"}, n_ram_wr - m0, int'(exp_ram));
      if (exp_reg || exp_ram) begin
        check(cap_addr == 7'(a), "R1 write address", cap_addr, a);
        check(cap_data == wdat(a), {tw, " write data"}, cap_data, wdat(a));
      end
      if (exp_reg)
        check(cap_mask == ((a == 10) ? 8'h7F : 8'hFF), "R8 write mask", cap_mask,
              (a == 10) ? 8'h7F : 8'hFF);
      addr_phase(a);
      data_read(1'b1, om, dm, oe);
      check(om == 1'b1, {tr, " drive in window"}, om, 1);
      check(dm == rdat(a), "R9 read data source", dm, rdat(a));
      check(oe == 1'b0, {tr, " release after window"}, oe, 0);
      check(n_reg_rd - rr0 == int'(a < 14), "R9 reg read strobe", n_reg_rd - rr0, int'(a < 14));
      check(n_ram_rd - mr0 == int'(exp_ram), "R9 ram read strobe", n_ram_rd - mr0, int'(exp_ram));
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_moto = 1'b1; as_i = 1'b0; ds_i = 1'b0; rw_i = 1'b1;
    cs_n_i = 1'b1; pf_inhibit = 1'b0; ad_i = 8'h00;
    waitc(5);
    check(ad_oe == 1'b0, "R11 no drive in reset", ad_oe, 0);
    check({reg_wr, ram_wr, reg_rd, ram_rd} == 4'b0, "R11 no strobes in reset",
          {reg_wr, ram_wr, reg_rd, ram_rd}, 0);
    rst_n = 1'b1;
    waitc(10);
    check(ad_oe == 1'b0, "R11 no drive after reset", ad_oe, 0);
    check(n_reg_wr + n_ram_wr + n_reg_rd + n_ram_rd == 0, "R11 no strobes after reset",
          n_reg_wr + n_ram_wr + n_reg_rd + n_ram_rd, 0);

    sweep(1'b1);
    sweep(1'b0);

    for (int m = 0; m < 2; m++) begin
      int w0, r0;
      logic om, oe;
      logic [7:0] dm;
      bus_moto = m[0]; idle();
      // R2: address strobe raised again before the data phase
      w0 = n_reg_wr + n_ram_wr;
      addr_phase(5);
      ad_i = 8'h05; as_i = 1'b1; waitc(PH);
      data_write(8'h77, 1'b1);
      check(n_reg_wr + n_ram_wr == w0, "R2 write after AS rise", n_reg_wr + n_ram_wr - w0, 0);
      r0 = n_reg_rd + n_ram_rd;
      data_read(1'b1, om, dm, oe);
      check(om == 1'b0, "R2 no drive after AS rise", om, 0);
      check(n_reg_rd + n_ram_rd == r0, "R2 read strobe after AS rise", n_reg_rd + n_ram_rd - r0, 0);
      as_i = 1'b0; waitc(PH);
      // R7: unselected cycle consumes the address
      w0 = n_reg_wr + n_ram_wr;
      addr_phase(3);
      data_write(8'h44, 1'b0);
      check(n_reg_wr + n_ram_wr == w0, "R7 unselected write", n_reg_wr + n_ram_wr - w0, 0);
      data_write(8'h45, 1'b1);
      check(n_reg_wr + n_ram_wr == w0, "R7 reuse of spent address", n_reg_wr + n_ram_wr - w0, 0);
      addr_phase(40);
      data_read(1'b0, om, dm, oe);
      check(om == 1'b0, "R7 unselected read drive", om, 0);
      r0 = n_reg_rd + n_ram_rd;
      data_read(1'b1, om, dm, oe);
      check(om == 1'b0, "R7 read on spent address", om, 0);
      check(n_reg_rd + n_ram_rd == r0, "R7 read strobe on spent address", n_reg_rd + n_ram_rd - r0, 0);
      // R10: inhibit blocks everything
      pf_inhibit = 1'b1; waitc(PH);
      w0 = n_reg_wr + n_ram_wr;
      addr_phase(2);
      data_write(8'h12, 1'b1);
      addr_phase(60);
      data_write(8'h34, 1'b1);
      check(n_reg_wr + n_ram_wr == w0, "R10 write under inhibit", n_reg_wr + n_ram_wr - w0, 0);
      r0 = n_reg_rd + n_ram_rd;
      addr_phase(60);
      data_read(1'b1, om, dm, oe);
      check(om == 1'b0, "R10 drive under inhibit", om, 0);
      check(n_reg_rd + n_ram_rd == r0, "R10 read strobe under inhibit", n_reg_rd + n_ram_rd - r0, 0);
      pf_inhibit = 1'b0; waitc(PH);
      // access works again once inhibit clears
      w0 = n_ram_wr;
      addr_phase(60);
      data_write(8'h56, 1'b1);
      check(n_ram_wr - w0 == 1, "R10 access after inhibit clears", n_ram_wr - w0, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule